// File: doc/BRIEF.md
# SPI Hold Suspend Gate

This block sits between the raw serial pins of an SPI target and its command front end. It lets the host pause a transaction part-way through by pulling an active-low hold pin, and later pick it up again without losing any state. While the pause is in force, the front end receives no clock pulses, its data input is frozen, and the serial output driver is switched off.

All pins are sampled on the rising edge of a fast system clock. The block runs a single hold flag and registers the gated clock, data and select it passes on, so the front end sees them one system cycle after the pins.

The hold pin only takes effect when the sampled serial clock is low. A change of the hold pin while the serial clock is high is deferred until the clock is next low. As a result, the front end never sees a clipped or partial clock pulse.

If chip select is released while a transaction is held, the block sends the front end a one-cycle reset request, so the paused transfer can never be resumed. With chip select high, the hold pin has no effect and every output stays idle.

Top module: `spi_hold_gate`

## Requirements
- R1: During reset, and in the system cycle after any sample with `cs_n` high, the outputs `sel`, `g_sck`, `g_si`, `held`, `xact_rst` (except as R8 states) and `so_oe` are all 0, whatever `hold_n`, `sck` and `si` do.
- R2: While selected and not held, `sel`=1 and `g_sck`/`g_si` equal `sck`/`si` as sampled one system cycle earlier. `so_pin` follows `fe_so` combinationally, and `so_oe` equals `fe_so_oe`.
- R3: A sample with `cs_n`=0, `sck`=0 and `hold_n`=0 sets `held` to 1 in the next cycle.
- R4: A sample with `held`=1, `cs_n`=0, `sck`=0 and `hold_n`=1 clears `held` in the next cycle.
- R5: `held` never changes on a sample where `sck`=1 and `cs_n`=0. A `hold_n` change made while `sck` is high takes effect at the first later sample with `sck` low.
- R6: While `held`=1, `g_sck`=0, `so_oe`=0, and `g_si` keeps the value it had when hold began.
- R7: After a hold is released, the front end sees exactly the `sck` rising edges that occurred outside the hold. A byte shifted in MSB first with a hold in the middle arrives intact.
- R8: A sample with `cs_n`=1 while `held`=1 gives a single-cycle `xact_rst`=1 in the next cycle and clears `held`. Raising `cs_n` while not held gives no `xact_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data input pin |
| hold_n | input | 1 | Hold pin, active low |
| fe_so | input | 1 | Serial output bit from the front end |
| fe_so_oe | input | 1 | Output enable requested by the front end |
| sel | output | 1 | Registered select to the front end |
| g_sck | output | 1 | Gated serial clock to the front end |
| g_si | output | 1 | Gated serial data to the front end |
| so_pin | output | 1 | Serial output value toward the pad |
| so_oe | output | 1 | Pad output enable; 0 means high impedance |
| held | output | 1 | Hold state in force |
| xact_rst | output | 1 | One-cycle transaction reset request |

## Verification
The bound properties check a set of rules on every cycle. They check that the gated clock and output enable stay low while held, and that gated data is frozen across a hold. They check that the hold flag never moves on a sample with the serial clock high, and that deselection idles everything. They also check that an abort while held always yields a reset pulse, and that the pulse never appears otherwise. Two things only the bench scenarios can show. One is that a byte split by a hold reaches the front end bit-exact, with no edge lost or added. The other is that a deferred hold change lands on the first low-clock sample after it.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic fe_so,
  input  logic fe_so_oe,
  output logic sel,
  output logic g_sck,
  output logic g_si,
  output logic so_pin,
  output logic so_oe,
  output logic held,
  output logic xact_rst
);

  logic held_nx;

  always_comb begin
    if (cs_n)
      held_nx = 1'b0;
    else if (sck)
      held_nx = held;
    else
      held_nx = ~hold_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      sel      <= 1'b0;
      g_sck    <= 1'b0;
      g_si     <= 1'b0;
      xact_rst <= 1'b0;
    end else begin
      held     <= held_nx;
      sel      <= ~cs_n;
      g_sck    <= ~cs_n & sck & ~held_nx;
      xact_rst <= cs_n & held;
      if (cs_n)
        g_si <= 1'b0;
      else if (!held_nx)
        g_si <= si;
    end
  end

  assign so_pin = fe_so;
  assign so_oe  = fe_so_oe & sel & ~held;

endmodule

module spi_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic sel,
  input logic g_sck,
  input logic g_si,
  input logic so_oe,
  input logic held,
  input logic xact_rst
);

  AST_IDLE_WHEN_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (!sel && !g_sck && !g_si && !held && !so_oe)); // R1
  AST_HELD_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (!g_sck && !so_oe)); // R6
  AST_HELD_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(g_si)); // R6
  AST_NO_MOVE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cs_n) && $past(sck)) |-> (held == $past(held))); // R5
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && cs_n) |=> (xact_rst && !held)); // R8
  AST_PULSE_ONLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    xact_rst |-> ($past(held) && $past(cs_n))); // R8
  AST_ENTER_LOW_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !$past(sck)); // R3

endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sel(sel),
  .g_sck(g_sck), .g_si(g_si), .so_oe(so_oe), .held(held), .xact_rst(xact_rst)
);

// File: tb/test_spi_hold_gate.sv
`timescale 1ns/1ps
module test_spi_hold_gate;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1, fe_so = 0, fe_so_oe = 0;
  logic sel, g_sck, g_si, so_pin, so_oe, held, xact_rst;
  int total = 0, bad = 0;
  bit done = 0;
  bit m_held, m_sel, m_sck, m_si, m_xr;
  bit prev_gsck;
  logic [7:0] cap;
  int edges;

  always #4 clk = ~clk;

  spi_hold_gate i_spi_hold_gate (.*);

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    if (!rst_n) begin
      m_held = 0; m_sel = 0; m_sck = 0; m_si = 0; m_xr = 0;
    end else begin
      m_xr  = cs_n && m_held;
      m_sel = !cs_n;
      if (cs_n) m_held = 0;
      else if (!sck) m_held = !hold_n;
      m_sck = !cs_n && sck && !m_held;
      if (cs_n) m_si = 0;
      else if (!m_held) m_si = si;
    end
    @(negedge clk);
    check({tag, " outputs"}, {sel, g_sck, g_si, held, xact_rst, so_oe, so_pin},
          {m_sel, m_sck, m_si, m_held, m_xr, fe_so_oe && m_sel && !m_held, fe_so});
    if (g_sck && !prev_gsck) begin
      cap = {cap[6:0], g_si};
      edges++;
    end
    prev_gsck = g_sck;
  endtask

  task automatic send_bit(input bit v, input string tag);
    si = v; sck = 0; cyc(tag); cyc(tag);
    sck = 1; cyc(tag); cyc(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    prev_gsck = 0; cap = 0; edges = 0;
    // R1 reset state
    cs_n = 0; hold_n = 0; fe_so_oe = 1;
    repeat (3) cyc("R1 reset");
    check("R1 held in reset", held, 0);
    rst_n = 1; cs_n = 1; hold_n = 1;
    cyc("R1");
    // R1 deselected: pins toggle, no effect
    for (int i = 0; i < 8; i++) begin
      sck = i[0]; si = i[1]; hold_n = i[2]; fe_so = i[0];
      cyc("R1 desel");
      check("R1 so_oe idle", so_oe, 0);
      check("R1 held idle", held, 0);
    end
    // R2 pass-through
    cs_n = 0; sck = 0; hold_n = 1; fe_so_oe = 1;
    cyc("R2");
    check("R2 sel", sel, 1);
    send_bit(1, "R2"); send_bit(0, "R2");
    fe_so = 1; cyc("R2");
    check("R2 so_oe", so_oe, 1);
    check("R2 so_pin", so_pin, 1);
    fe_so_oe = 0; #1 check("R2 so_oe off", so_oe, 0);
    fe_so_oe = 1;
    cs_n = 1; sck = 0; cyc("R2"); cyc("R2");
    // R7 byte 8'hA5 with a hold after three bits
    cap = 0; edges = 0; prev_gsck = 0;
    cs_n = 0; cyc("R7");
    send_bit(1, "R7"); send_bit(0, "R7"); send_bit(1, "R7");
    hold_n = 0; cyc("R5"); cyc("R5");
    check("R5 entry deferred while sck high", held, 0);
    sck = 0; cyc("R3");
    check("R3 held entered", held, 1);
    for (int i = 0; i < 3; i++) begin
      sck = 1; si = ~si; cyc("R6"); cyc("R6");
      sck = 0; cyc("R6");
      check("R6 no clock while held", g_sck, 0);
      check("R6 so_oe off while held", so_oe, 0);
    end
    check("R6 no edges during hold", edges, 3);
    sck = 1; cyc("R6");
    hold_n = 1; cyc("R5");
    check("R5 release deferred while sck high", held, 1);
    sck = 0; cyc("R4");
    check("R4 released", held, 0);
    send_bit(0, "R7"); send_bit(0, "R7"); send_bit(1, "R7");
    send_bit(0, "R7"); send_bit(1, "R7");
    sck = 0; cyc("R7");
    check("R7 edge count", edges, 8);
    check("R7 byte resumed", cap, 8'hA5);
    // R8 abort while held
    hold_n = 0; cyc("R8");
    check("R8 held before abort", held, 1);
    cs_n = 1; cyc("R8");
    check("R8 abort pulse", xact_rst, 1);
    check("R8 held cleared", held, 0);
    cyc("R8");
    check("R8 pulse single", xact_rst, 0);
    check("R1 hold ignored when deselected", held, 0);
    // R8 no pulse on normal deselect
    cs_n = 0; hold_n = 1; cyc("R8");
    send_bit(1, "R8");
    sck = 0; cs_n = 1; cyc("R8");
    check("R8 no pulse when not held", xact_rst, 0);
    cyc("R8");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule